// File: doc/BRIEF.md
# Paged Bitmap Video Fetch Unit

This block sits between a CRT timing controller and a frame-buffer DRAM on a monochrome bitmap display of 1024x800 pixels. The display is 16 cells across and 50 cell rows down. Each cell is 64 pixels wide and 16 scan lines tall. On each cell boundary the controller presents its memory address, its scan-line (row) address and the cell column. The block forms a 16-bit virtual display address from these. The upper part of that address indexes a host-writable page-mapping RAM, and the entry it returns replaces the upper part to give a physical word address. The block then issues a single DRAM read for the eight bytes of the cell.

The returned 64 bits go into a back buffer. At the next cell boundary they move into a shift register, which emits one pixel per pixel clock. The display therefore runs one cell behind the fetch, and every fetch has a full cell period (64 clocks) to complete. Because every 64-pixel span goes through the page table, the frame buffer can be scattered across physical memory.

The host fills the page table through a write port with byte enables. When a host write and a display lookup fall in the same cycle, the display lookup is served and the host write is lost. For cells marked not visible, no fetch is issued and the pixel output stays white for the whole cell period.

Top module: `paged_pixel_fetch`

## Requirements
- R1: While rst_ni is low, rd_req_o is 0 and pix_black_o is 0 (white).
- R2: The virtual address is {crtc_ma_i[11:4], crtc_ra_i[3:0], cell_col_i[3:0]}. Its low 6 bits, {crtc_ra_i[1:0], cell_col_i}, appear unchanged at rd_addr_o[8:3]. crtc_ma_i[13:12] and crtc_ra_i[4] are ignored.
- R3: The page-table index is the virtual address bits [15:6], which is {crtc_ma_i[11:4], crtc_ra_i[3:2]}. The 16-bit entry at that index appears at rd_addr_o[24:9].
- R4: A clock edge that samples cell_start_i=1 together with fetch_en_i=1 makes rd_req_o high for exactly the cycle after the next edge, which is two edges later. rd_addr_o[2:0] is 0 in that cycle, so the 8-byte cell is addressed at physical word address * 8.
- R5: An edge that samples cell_start_i=1 with fetch_en_i=0 issues no read. The whole following cell period then shows white.
- R6: In rd_data_i, byte k sits at bits [8k+7:8k]. Pixel 8k+b of a cell is bit b of byte k, so bit 0 of byte 0 is the leftmost pixel. A 1 bit shows as pix_black_o=1 (black) and a 0 bit as 0 (white).
- R7: Data fetched for the cell started at one cell_start_i edge is shown after the following cell_start_i edge. Pixel i of the cell is on pix_black_o during the i-th cycle after that edge, for i = 0 to 63.
- R8: Once 64 pixels of a cell have been emitted without a new cell_start_i, pix_black_o stays 0.
- R9: A host write with host_we_i=1 updates the page-table entry at host_addr_i. host_be_i[0] enables bits [7:0] and host_be_i[1] enables bits [15:8]. Disabled bytes keep their value.
- R10: A host write in the same cycle as a lookup (cell_start_i=1 with fetch_en_i=1) is discarded, and the entry keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_start_i | input | 1 | Strobe on the first clock of each cell period |
| fetch_en_i | input | 1 | The cell described this cycle is visible |
| crtc_ma_i | input | 14 | Controller memory address |
| crtc_ra_i | input | 5 | Controller scan-line address |
| cell_col_i | input | 4 | Cell column within the line |
| host_we_i | input | 1 | Page-table write strobe |
| host_be_i | input | 2 | Page-table byte enables |
| host_addr_i | input | 10 | Page-table index |
| host_wdata_i | input | 16 | Page-table write data |
| rd_req_o | output | 1 | DRAM cell read request, one cycle |
| rd_addr_o | output | 25 | Byte address of the first byte of the cell |
| rd_valid_i | input | 1 | DRAM read data valid |
| rd_data_i | input | 64 | Eight cell bytes, byte k at bits [8k+7:8k] |
| pix_black_o | output | 1 | Serial pixel, 1 = black |

## Verification
The bench picks controller addresses that place every virtual-address field in a different page-table index. It also sets the ignored upper bits, so a design that swapped or shifted a field, or that used those bits, would fetch from a wrong address. It checks every pixel of every cell against the memory model's bytes. Reversed bit order, reversed byte order, inverted colour or a cell shown one period early or late would each fail many pixel comparisons. Partial-byte page writes and a write that collides with a lookup are followed by fetches through the same entry, so a design that ignored byte enables or let the colliding write through would emit a wrong address. Hidden cells check both the absent request and the white period that follows.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int MA_W       = 14;
  localparam int RA_W       = 5;
  localparam int COL_W      = 4;
  localparam int MA_HI      = 11;
  localparam int MA_LO      = 4;
  localparam int ROW_W      = 4;
  localparam int PAGE_W     = 6;
  localparam int MAP_DW     = 16;
  localparam int CELL_PIX   = 64;

  localparam int VA_W       = (MA_HI - MA_LO + 1) + ROW_W + COL_W;
  localparam int MAP_AW     = VA_W - PAGE_W;
  localparam int CELL_BYTES = CELL_PIX / 8;
  localparam int BYTE_SH    = $clog2(CELL_BYTES);
  localparam int PADDR_W    = MAP_DW + PAGE_W + BYTE_SH;
  localparam int LANES      = MAP_DW / 8;

  typedef logic [VA_W-1:0] vaddr_t;

  typedef struct packed {
    logic [MAP_AW-1:0] page;
    logic [PAGE_W-1:0] off;
  } vsplit_t;

  function automatic vaddr_t make_vaddr(input logic [MA_W-1:0]  ma,
                                        input logic [RA_W-1:0]  ra,
                                        input logic [COL_W-1:0] col);
    return {ma[MA_HI:MA_LO], ra[ROW_W-1:0], col};
  endfunction
endpackage

// File: rtl/pf_map_ram.sv
module pf_map_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [DW/8-1:0] wr_be_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i
);
  localparam int DEPTH = 1 << AW;
  localparam int NB    = DW / 8;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] wmask;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign wmask[8*g +: 8] = {8{wr_be_i[g]}};
  end

  // display lookup owns the single port
  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      rd_data_o <= mem[rd_idx_i];
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= (mem[wr_idx_i] & ~wmask) | (wr_data_i & wmask);
    end
  end
endmodule

// File: rtl/pf_addr_xlate.sv
module pf_addr_xlate
  import pf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lookup_i,
  input  logic [MA_W-1:0]    ma_i,
  input  logic [RA_W-1:0]    ra_i,
  input  logic [COL_W-1:0]   col_i,
  output logic [MAP_AW-1:0]  map_idx_o,
  input  logic [MAP_DW-1:0]  map_q_i,
  output logic               rd_req_o,
  output logic [PADDR_W-1:0] rd_addr_o
);
  vsplit_t           vs;
  logic              s1_vld_q;
  logic [PAGE_W-1:0] off_q;

  assign vs        = vsplit_t'(make_vaddr(ma_i, ra_i, col_i));
  assign map_idx_o = vs.page;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      off_q     <= '0;
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      s1_vld_q <= lookup_i;
      if (lookup_i) off_q <= vs.off;
      rd_req_o <= s1_vld_q;
      if (s1_vld_q) rd_addr_o <= {map_q_i, off_q, {BYTE_SH{1'b0}}};
    end
  end
endmodule

// File: rtl/pf_pix_shift.sv
module pf_pix_shift #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         next_vis_i,
  input  logic         fill_i,
  input  logic [W-1:0] fill_data_i,
  output logic         pix_o
);
  logic [W-1:0] back_q;
  logic         back_vis_q;
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      back_q     <= '0;
      back_vis_q <= 1'b0;
      sh_q       <= '0;
    end else begin
      if (fill_i) back_q <= fill_data_i;
      if (start_i) begin
        sh_q       <= back_vis_q ? back_q : '0;
        back_vis_q <= next_vis_i;
      end else begin
        sh_q <= sh_q >> 1;
      end
    end
  end

  assign pix_o = sh_q[0];
endmodule

// File: rtl/paged_pixel_fetch.sv
module paged_pixel_fetch
  import pf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cell_start_i,
  input  logic               fetch_en_i,
  input  logic [MA_W-1:0]    crtc_ma_i,
  input  logic [RA_W-1:0]    crtc_ra_i,
  input  logic [COL_W-1:0]   cell_col_i,
  input  logic               host_we_i,
  input  logic [LANES-1:0]   host_be_i,
  input  logic [MAP_AW-1:0]  host_addr_i,
  input  logic [MAP_DW-1:0]  host_wdata_i,
  output logic               rd_req_o,
  output logic [PADDR_W-1:0] rd_addr_o,
  input  logic               rd_valid_i,
  input  logic [CELL_PIX-1:0] rd_data_i,
  output logic               pix_black_o
);
  logic              lookup;
  logic [MAP_AW-1:0] map_idx;
  logic [MAP_DW-1:0] map_q;

  assign lookup = cell_start_i & fetch_en_i;

  pf_addr_xlate u_xlate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lookup_i  (lookup),
    .ma_i      (crtc_ma_i),
    .ra_i      (crtc_ra_i),
    .col_i     (cell_col_i),
    .map_idx_o (map_idx),
    .map_q_i   (map_q),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o)
  );

  pf_map_ram #(.AW(MAP_AW), .DW(MAP_DW)) u_map (
    .clk_i     (clk_i),
    .rd_en_i   (lookup),
    .rd_idx_i  (map_idx),
    .rd_data_o (map_q),
    .wr_en_i   (host_we_i),
    .wr_be_i   (host_be_i),
    .wr_idx_i  (host_addr_i),
    .wr_data_i (host_wdata_i)
  );

  pf_pix_shift #(.W(CELL_PIX)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cell_start_i),
    .next_vis_i  (fetch_en_i),
    .fill_i      (rd_valid_i),
    .fill_data_i (rd_data_i),
    .pix_o       (pix_black_o)
  );
endmodule

// File: rtl/pf_checker.sv
module pf_checker
  import pf_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cell_start_i,
  input logic               fetch_en_i,
  input logic [RA_W-1:0]    crtc_ra_i,
  input logic [COL_W-1:0]   cell_col_i,
  input logic               rd_req_o,
  input logic [PADDR_W-1:0] rd_addr_o,
  input logic               pix_black_o
);
  localparam int CW = $clog2(CELL_PIX + 1);
  logic [CW-1:0] since_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_start <= CW'(CELL_PIX);
    else if (cell_start_i) since_start <= '0;
    else if (since_start < CW'(CELL_PIX)) since_start <= since_start + 1'b1;
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!rd_req_o && !pix_black_o);
    end
  end

  p_offset_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[8:3] == $past({crtc_ra_i[1:0], cell_col_i}, 2));

  p_req_origin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> $past(cell_start_i && fetch_en_i, 2));

  p_hidden_no_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cell_start_i && !fetch_en_i, 2) |-> !rd_req_o);

  p_white_after_cell_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_black_o |-> since_start < CW'(CELL_PIX));
endmodule

bind paged_pixel_fetch pf_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cell_start_i (cell_start_i),
  .fetch_en_i   (fetch_en_i),
  .crtc_ra_i    (crtc_ra_i),
  .cell_col_i   (cell_col_i),
  .rd_req_o     (rd_req_o),
  .rd_addr_o    (rd_addr_o),
  .pix_black_o  (pix_black_o)
);

// File: tb/sim_paged_pixel_fetch.sv
module sim_paged_pixel_fetch;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cell_start_i = 1'b0;
  logic        fetch_en_i = 1'b0;
  logic [13:0] crtc_ma_i = '0;
  logic [4:0]  crtc_ra_i = '0;
  logic [3:0]  cell_col_i = '0;
  logic        host_we_i = 1'b0;
  logic [1:0]  host_be_i = '0;
  logic [9:0]  host_addr_i = '0;
  logic [15:0] host_wdata_i = '0;
  logic        rd_req_o;
  logic [24:0] rd_addr_o;
  logic        rd_valid_i = 1'b0;
  logic [63:0] rd_data_i = '0;
  logic        pix_black_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [24:0] addr_q[$];
  logic        pix_q[$];
  logic [15:0] map_m [1024];
  logic [63:0] prev_word = '0;
  logic        prev_vis = 1'b0;
  string       cur_req = "R7";

  always #4 clk_i = ~clk_i;

  paged_pixel_fetch u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [24:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ 8'h3c;
  endfunction

  function automatic logic [63:0] cell_word(input logic [24:0] base);
    logic [63:0] w;
    for (int k = 0; k < 8; k++) w[8*k +: 8] = mem_byte(base + 25'(k));
    return w;
  endfunction

  // DRAM model: fixed three-cycle latency
  logic [24:0] pend_addr;
  int          pend_cnt = 0;
  always @(negedge clk_i) begin
    rd_valid_i = 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt--;
      if (pend_cnt == 0) begin
        rd_valid_i = 1'b1;
        rd_data_i  = cell_word(pend_addr);
      end
    end
    if (rd_req_o) begin
      pend_addr = rd_addr_o;
      pend_cnt  = 3;
    end
  end

  // monitors
  always @(negedge clk_i) begin
    if (rst_ni && rd_req_o) begin
      if (addr_q.size() == 0) chk(0, "R3 unexpected request", longint'(rd_addr_o), 0);
      else begin
        logic [24:0] e;
        e = addr_q.pop_front();
        chk(rd_addr_o == e, "R2/R3 address", longint'(rd_addr_o), longint'(e));
      end
    end
    if (rst_ni && pix_q.size() > 0) begin
      logic ep;
      ep = pix_q.pop_front();
      chk(pix_black_o == ep, {cur_req, " R6 pixel"}, longint'(pix_black_o), longint'(ep));
    end
  end

  task automatic host_wr(input logic [9:0] idx, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk_i); #1;
    host_we_i = 1'b1; host_be_i = be; host_addr_i = idx; host_wdata_i = d;
    @(negedge clk_i); #1;
    host_we_i = 1'b0;
    if (be[0]) map_m[idx][7:0]  = d[7:0];   // R9
    if (be[1]) map_m[idx][15:8] = d[15:8];
  endtask

  task automatic do_cell(input logic [13:0] ma, input logic [4:0] ra, input logic [3:0] col,
                         input logic en, input logic hw, input logic [9:0] hidx,
                         input logic [15:0] hd, input string req);
    logic [9:0]  idx;
    logic [24:0] ea;
    idx = {ma[11:4], ra[3:2]};
    ea  = {map_m[idx], ra[1:0], col, 3'b000};
    @(negedge clk_i); #1;
    cur_req = req;
    for (int i = 0; i < 64; i++) pix_q.push_back(prev_vis & prev_word[i]);
    if (en) addr_q.push_back(ea);
    cell_start_i = 1'b1; fetch_en_i = en;
    crtc_ma_i = ma; crtc_ra_i = ra; cell_col_i = col;
    host_we_i = hw; host_be_i = 2'b11; host_addr_i = hidx; host_wdata_i = hd;
    if (hw && !en) map_m[hidx] = hd;  // R10: only dropped on lookup
    @(negedge clk_i); #1;
    cell_start_i = 1'b0; host_we_i = 1'b0;
    @(negedge clk_i);
    chk(rd_req_o == en, en ? "R4 request timing" : "R5 no request", longint'(rd_req_o), longint'(en));
    prev_vis  = en;
    prev_word = cell_word(ea);
    repeat (61) @(negedge clk_i);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(rd_req_o == 1'b0, "R1 reset request", longint'(rd_req_o), 0);
    chk(pix_black_o == 1'b0, "R1 reset pixel", longint'(pix_black_o), 0);
    #1 rst_ni = 1'b1;

    host_wr(10'h012, 2'b11, 16'h1234);
    host_wr(10'h3ff, 2'b11, 16'hbeef);
    host_wr(10'h000, 2'b11, 16'h0a5c);
    host_wr(10'h155, 2'b11, 16'h7001);
    host_wr(10'h2aa, 2'b11, 16'h5a5a);

    do_cell(14'h0040, 5'd9,  4'd5,  1, 0, '0, '0, "R7 first");
    do_cell(14'h3ff0, 5'd15, 4'd15, 1, 0, '0, '0, "R2 upper bits");
    do_cell(14'h0000, 5'd3,  4'd0,  1, 0, '0, '0, "R3 page zero");
    do_cell(14'h0aa0, 5'h1a, 4'd9,  1, 0, '0, '0, "R2 ra4 ignored");
    do_cell(14'h0550, 5'd4,  4'd7,  0, 0, '0, '0, "R5 hidden");
    do_cell(14'h0550, 5'd4,  4'd7,  1, 0, '0, '0, "R5 after hidden");

    host_wr(10'h012, 2'b01, 16'h00ff);
    do_cell(14'h0040, 5'd8,  4'd1,  1, 0, '0, '0, "R9 low byte");
    host_wr(10'h012, 2'b10, 16'hab00);
    do_cell(14'h0040, 5'd10, 4'd14, 1, 0, '0, '0, "R9 high byte");

    do_cell(14'h0000, 5'd0,  4'd2,  1, 1, 10'h3ff, 16'h1111, "R10 collide");
    do_cell(14'h3ff0, 5'd12, 4'd3,  1, 0, '0, '0, "R10 entry kept");
    do_cell(14'h0000, 5'd0,  4'd0,  0, 0, '0, '0, "R8 flush");
    do_cell(14'h0000, 5'd0,  4'd0,  0, 0, '0, '0, "R8 blank");
    repeat (70) begin
      @(negedge clk_i);
      chk(pix_black_o == 1'b0, "R8 idle white", longint'(pix_black_o), 0);
    end
    chk(addr_q.size() == 0, "R4 all requests seen", longint'(addr_q.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule